// File: doc/BRIEF.md
# Parallel Code-Memory Programming Controller

This block is the device-side engine that an external programmer talks to when it loads, checks and clears a small on-chip code store. The programmer selects an operation on a 4-bit mode input and applies a byte to the data lines. It then pulses an active-low program strobe while a high-voltage-enable flag is set. The block keeps an internal byte address. That address is cleared whenever the enable input rises and is stepped by a separate advance pulse, so the programmer never presents an address.

Byte programming and lock-bit programming are self-timed by a cycle counter. Progress can be watched in two ways: on the ready output, or by reading back the byte just written, whose bit 7 is inverted until the write is done. Chip erase restores every byte to FFh and clears both lock bits, but only after the strobe has been held low for a long, parameterised time. Two lock bits restrict the programmer. The first one stops further code writes. With both set, verify reads are refused as well. A signature mode returns fixed identification bytes.

The bidirectional data lines are split into an input bus, an output bus and an output enable for the pad ring. The code store is a register array inside the block.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After synchronous active-low reset, every byte of the code store reads FFh, both lock bits are clear, the address is 000h and `ready` is high.
- R2: A rising edge on `prog_en` clears the address to 000h. While `prog_en` is high, each rising edge on `addr_step` adds one, and stepping past the last address (DEPTH-1, 7FFh by default) gives 000h.
- R3: With `prog_en` and `hv_en` high and mode 4'h1 (write code), a falling edge on `prog_strobe_n` starts a byte write at the current address. With `hv_en` low the strobe has no effect.
- R4: An accepted write (code or lock bit) drives `ready` low from the clock edge that sees the strobe fall for exactly WRITE_CYC cycles, after which `ready` returns high.
- R5: In mode 4'h2 (verify), while a code write is in progress and the address equals the address written, `data_out[7]` is the complement of the stored bit 7 and bits 6:0 are the stored bits. After completion all eight bits are true.
- R6: Strobe falls that arrive while `ready` is low are ignored.
- R7: In mode 4'h5 (erase), with `prog_en` and `hv_en` high, holding `prog_strobe_n` low for ERASE_CYC consecutive clock edges sets every byte to FFh and clears both lock bits. A shorter hold changes nothing.
- R8: Mode 4'h3 sets lock bit 1 and mode 4'h4 sets lock bit 2. Both are strobed and timed like a code write. With lock 1 set, code writes are ignored. With both set, verify reads leave `data_oe` low. Only erase or reset clears a lock bit.
- R9: In mode 4'h6 (signature), the block drives 1Eh at address 000h, 21h at address 001h and 00h at other addresses, whatever the lock bits are.
- R10: `data_oe` is high only while `prog_en` is high in verify mode (not blocked) or signature mode; otherwise it is low.
- R11: A code write stores the bitwise AND of the old byte and the new data, so a write can only clear bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Programming-mode enable; its rising edge clears the address |
| hv_en | input | 1 | High-voltage-present flag; must be high to write or erase |
| prog_strobe_n | input | 1 | Active-low program strobe |
| addr_step | input | 1 | Address advance pulse, rising edge counts |
| mode_sel | input | 4 | Operation select (see R3, R5, R7, R8, R9) |
| data_in | input | 8 | Data from the programmer |
| data_out | output | 8 | Data returned to the programmer |
| data_oe | output | 1 | Output enable for the data pads |
| ready | output | 1 | High when no timed write is in progress |

## Verification
Every input edge is registered once, so an address step, a write start, a lock set and an erase all take effect at the clock edge that first samples the new input level. The read data and `data_oe` follow the mode and the address combinationally. The bench therefore drives on falling clock edges and checks one falling edge after the stimulus. It checks `ready` low at the first falling edge after the strobe edge, still low after WRITE_CYC-1 further edges and high after WRITE_CYC. It samples the inverted bit 7 inside that window and the true byte just after it. Erase is held for exactly ERASE_CYC-3 edges and then ERASE_CYC+2 edges, so that both sides of the threshold are checked.

// File: rtl/flash_prog_pkg.sv
// Shared mode encodings and fixed identification bytes for the
// code-memory programming controller. Assumes a 4-bit mode bus.
package flash_prog_pkg;

    typedef enum logic [3:0] {
        MD_IDLE    = 4'h0,
        MD_WR_CODE = 4'h1,
        MD_RD_CODE = 4'h2,
        MD_WR_LB1  = 4'h3,
        MD_WR_LB2  = 4'h4,
        MD_ERASE   = 4'h5,
        MD_RD_SIG  = 4'h6
    } prog_mode_e;

    localparam logic [7:0] SIG_BYTE0 = 8'h1E;
    localparam logic [7:0] SIG_BYTE1 = 8'h21;
    localparam logic [7:0] SIG_OTHER = 8'h00;

endpackage

// File: rtl/flash_addr_ctr.sv
// Byte address counter for the code store. A clear wins over a step.
// Assumes the store depth is a power of two, so wrap-around is the
// natural overflow of an AW-bit counter.
module flash_addr_ctr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr
);

    // Hold, clear or increment the current address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (clear)
            addr <= '0;
        else if (step)
            addr <= addr + AW'(1);
    end

endmodule

// File: rtl/flash_op_timer.sv
// Self-timed write duration. A start pulse makes busy high for exactly
// CYC clock cycles. Assumes the caller never starts while busy.
module flash_op_timer #(
    parameter int CYC = 14400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] remain;

    // Load the cycle count on start, count down and drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CYC - 1);
        end else if (busy) begin
            if (remain == '0)
                busy <= 1'b0;
            else
                remain <= remain - CW'(1);
        end
    end

endmodule

// File: rtl/flash_erase_timer.sv
// Measures how long the erase strobe stays low. fire is a single-cycle
// pulse on the CYC-th consecutive cycle with hold high. The count
// saturates, so one hold gives one pulse. Assumes CYC >= 1.
module flash_erase_timer #(
    parameter int CYC = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic fire
);

    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] held;

    assign fire = hold && (held == CW'(CYC - 1));

    // Count consecutive hold cycles and restart whenever hold drops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (!hold)
            held <= '0;
        else if (held != CW'(CYC))
            held <= held + CW'(1);
    end

endmodule

// File: rtl/flash_code_array.sv
// Register model of the code store. A write ANDs the new data into the
// stored byte, because cells can only go from 1 to 0. Erase and reset
// both set every byte to all ones. The read is asynchronous.
module flash_code_array #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    assign rdata = cells[addr];

    // Blank the whole store on reset or erase, otherwise clear bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= '1;
        end else if (we) begin
            cells[addr] <= cells[addr] & wdata;
        end
    end

endmodule

// File: rtl/flash_prog_ctrl.sv
// Top of the programming controller. It registers the enable, step and
// strobe inputs to find their edges, decodes the mode, holds the two
// lock bits and the poll context, and muxes the data returned to the
// programmer. Assumes all inputs are already synchronous to clk.
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int DEPTH     = 2048,
    parameter int WRITE_CYC = 14400,
    parameter int ERASE_CYC = 120000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_en,
    input  logic       hv_en,
    input  logic       prog_strobe_n,
    input  logic       addr_step,
    input  logic [3:0] mode_sel,
    input  logic [7:0] data_in,
    output logic [7:0] data_out,
    output logic       data_oe,
    output logic       ready
);

    localparam int AW = $clog2(DEPTH);

    logic          pe_q, step_q, strb_q;
    logic          pe_rise, step_go, strb_fall;
    logic          wr_active, busy, start_ok;
    logic          code_we, lb1_set, lb2_set, op_start;
    logic          erase_hold, erase_fire;
    logic          lb1, lb2, poll_code;
    logic [AW-1:0] cur_addr, last_addr;
    logic [7:0]    arr_rdata;

    // Keep last-cycle copies of the edge-sensitive inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q   <= 1'b0;
            step_q <= 1'b0;
            strb_q <= 1'b1;
        end else begin
            pe_q   <= prog_en;
            step_q <= addr_step;
            strb_q <= prog_strobe_n;
        end
    end

    assign pe_rise   = prog_en & ~pe_q;
    assign step_go   = prog_en & addr_step & ~step_q;
    assign strb_fall = strb_q & ~prog_strobe_n;

    assign wr_active  = prog_en & hv_en;
    assign start_ok   = wr_active & strb_fall & ~busy;
    assign code_we    = start_ok & (mode_sel == MD_WR_CODE) & ~lb1;
    assign lb1_set    = start_ok & (mode_sel == MD_WR_LB1);
    assign lb2_set    = start_ok & (mode_sel == MD_WR_LB2);
    assign op_start   = code_we | lb1_set | lb2_set;
    assign erase_hold = wr_active & ~prog_strobe_n & (mode_sel == MD_ERASE) & ~busy;

    flash_addr_ctr #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pe_rise),
        .step  (step_go),
        .addr  (cur_addr)
    );

    flash_op_timer #(.CYC(WRITE_CYC)) u_wtimer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (op_start),
        .busy  (busy)
    );

    flash_erase_timer #(.CYC(ERASE_CYC)) u_etimer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (erase_hold),
        .fire  (erase_fire)
    );

    flash_code_array #(.DEPTH(DEPTH), .DW(8)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase_fire),
        .we    (code_we),
        .addr  (cur_addr),
        .wdata (data_in),
        .rdata (arr_rdata)
    );

    // Set the lock bits on accepted lock writes; only erase or reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_fire) begin
            lb1 <= 1'b0;
            lb2 <= 1'b0;
        end else begin
            if (lb1_set) lb1 <= 1'b1;
            if (lb2_set) lb2 <= 1'b1;
        end
    end

    // Remember the target of the latest timed write for status polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_code <= 1'b0;
            last_addr <= '0;
        end else if (op_start) begin
            poll_code <= code_we;
            last_addr <= cur_addr;
        end
    end

    // Choose what the data pads return and whether they are driven.
    always_comb begin
        data_oe  = 1'b0;
        data_out = 8'h00;
        if (prog_en) begin
            if (mode_sel == MD_RD_CODE && !(lb1 && lb2)) begin
                data_oe  = 1'b1;
                data_out = arr_rdata;
                if (busy && poll_code && cur_addr == last_addr)
                    data_out[7] = ~arr_rdata[7];
            end else if (mode_sel == MD_RD_SIG) begin
                data_oe = 1'b1;
                if (cur_addr == AW'(0))
                    data_out = SIG_BYTE0;
                else if (cur_addr == AW'(1))
                    data_out = SIG_BYTE1;
                else
                    data_out = SIG_OTHER;
            end
        end
    end

    assign ready = ~busy;

endmodule

// File: rtl/flash_prog_chk.sv
// Temporal checks on the programming controller, attached by bind.
// Assumes it sees the top's internal address, step, lock and erase nets.
module flash_prog_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_en,
    input logic          hv_en,
    input logic          prog_strobe_n,
    input logic [3:0]    mode_sel,
    input logic          ready,
    input logic          data_oe,
    input logic [AW-1:0] addr,
    input logic          step_go,
    input logic          pe_rise,
    input logic          lb1,
    input logic          lb2,
    input logic          erase_fire
);

    // R2
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_go) && !$past(pe_rise) && ($past(addr) == {AW{1'b1}}))
        |-> (addr == '0));

    // R4
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> ($past(prog_en) && $past(hv_en) && !$past(prog_strobe_n)));

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lb1) && !$past(erase_fire)) |-> lb1);

    // R7
    erase_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(erase_fire)) |-> (!lb1 && !lb2));

    // R8
    verify_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb1 && lb2 && mode_sel == 4'h2) |-> !data_oe);

    // R10
    pads_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |-> !data_oe);

endmodule

bind flash_prog_ctrl flash_prog_chk #(.AW(AW)) u_prog_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_en       (prog_en),
    .hv_en         (hv_en),
    .prog_strobe_n (prog_strobe_n),
    .mode_sel      (mode_sel),
    .ready         (ready),
    .data_oe       (data_oe),
    .addr          (cur_addr),
    .step_go       (step_go),
    .pe_rise       (pe_rise),
    .lb1           (lb1),
    .lb2           (lb2),
    .erase_fire    (erase_fire)
);

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;
    localparam int WCYC       = 20;
    localparam int ECYC       = 50;

    localparam logic [3:0] M_IDLE = 4'h0, M_WR = 4'h1, M_RD = 4'h2,
                           M_LB1 = 4'h3, M_LB2 = 4'h4, M_ER = 4'h5, M_SIG = 4'h6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b0;
    logic       hv_en = 1'b0;
    logic       prog_strobe_n = 1'b1;
    logic       addr_step = 1'b0;
    logic [3:0] mode_sel = 4'h0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic       ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model [DEPTH];
    int         addr_m = 0;
    bit         lb1_m = 0, lb2_m = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_prog_ctrl #(.DEPTH(DEPTH), .WRITE_CYC(WCYC), .ERASE_CYC(ECYC)) i_flash_prog_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .prog_en       (prog_en),
        .hv_en         (hv_en),
        .prog_strobe_n (prog_strobe_n),
        .addr_step     (addr_step),
        .mode_sel      (mode_sel),
        .data_in       (data_in),
        .data_out      (data_out),
        .data_oe       (data_oe),
        .ready         (ready)
    );

    function automatic logic [7:0] poll_byte(input logic [7:0] b);
        return {~b[7], b[6:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic step_addr();
        addr_step = 1'b1;
        tick();
        addr_step = 1'b0;
        tick();
        if (prog_en) addr_m = (addr_m + 1) % DEPTH;
    endtask

    task automatic restart_en();
        prog_en = 1'b0;
        tick();
        prog_en = 1'b1;
        tick();
        addr_m = 0;
    endtask

    task automatic read_chk(input string tag);
        bit blocked;
        mode_sel = M_RD;
        tick();
        blocked = lb1_m && lb2_m;
        chk({tag, " oe"}, 32'(data_oe), 32'(!blocked));
        if (!blocked) chk({tag, " data"}, 32'(data_out), 32'(model[addr_m]));
    endtask

    task automatic prog_op(input logic [3:0] md, input logic [7:0] d, input bit spur, input string tag);
        bit acc;
        acc = prog_en && hv_en && !(md == M_WR && lb1_m);
        mode_sel = md;
        data_in = d;
        prog_strobe_n = 1'b0;
        tick();
        prog_strobe_n = 1'b1;
        if (acc) begin
            if (md == M_WR) model[addr_m] = model[addr_m] & d;
            else if (md == M_LB1) lb1_m = 1'b1;
            else lb2_m = 1'b1;
            chk({tag, " R4 ready low"}, 32'(ready), 32'd0);
            if (md == M_WR && !(lb1_m && lb2_m)) begin
                mode_sel = M_RD;
                #1;
                chk({tag, " R5 poll"}, 32'(data_out), 32'(poll_byte(model[addr_m])));
            end
            for (int i = 1; i < WCYC; i++) begin
                if (spur && i == 2) begin mode_sel = M_WR; data_in = 8'h00; prog_strobe_n = 1'b0; end
                if (spur && i == 3) begin prog_strobe_n = 1'b1; mode_sel = M_RD; end
                tick();
            end
            chk({tag, " R4 still busy"}, 32'(ready), 32'd0);
            tick();
            chk({tag, " R4 ready back"}, 32'(ready), 32'd1);
            if (md == M_WR) read_chk({tag, " R5 R6 true data"});
        end else begin
            tick();
            chk({tag, " ignored ready"}, 32'(ready), 32'd1);
        end
    endtask

    task automatic erase_op(input int hold);
        mode_sel = M_ER;
        prog_strobe_n = 1'b0;
        repeat (hold) tick();
        prog_strobe_n = 1'b1;
        tick();
        if (hold >= ECYC && prog_en && hv_en) begin
            for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
            lb1_m = 1'b0;
            lb2_m = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state, R10 pads idle while disabled
        chk("R1 ready after reset", 32'(ready), 32'd1);
        chk("R10 oe while disabled", 32'(data_oe), 32'd0);

        hv_en = 1'b1;
        restart_en();
        prog_op(M_WR, 8'h5A, 1'b1, "R3 first write");

        // R1 blank store sweep, R2 wrap past last address
        for (int a = 0; a < DEPTH; a++) begin
            read_chk("R1 sweep");
            step_addr();
        end
        read_chk("R2 wrap to 000h");
        repeat (5) step_addr();
        read_chk("R2 step");
        restart_en();
        read_chk("R2 clear on enable");

        // R9 signature bytes
        mode_sel = M_SIG;
        tick();
        chk("R9 sig0", 32'(data_out), 32'h1E);
        step_addr();
        chk("R9 sig1", 32'(data_out), 32'h21);
        step_addr();
        chk("R9 sig other", 32'(data_out), 32'h00);
        chk("R10 oe in signature", 32'(data_oe), 32'd1);

        // R11 AND semantics
        prog_op(M_WR, 8'hF0, 1'b0, "R11 a");
        prog_op(M_WR, 8'h3C, 1'b0, "R11 b");
        chk("R11 anded byte", 32'(model[addr_m]), 32'h30);
        read_chk("R11 readback");

        // R3 write without high voltage
        hv_en = 1'b0;
        prog_op(M_WR, 8'h00, 1'b0, "R3 hv low");
        read_chk("R3 hv low unchanged");
        hv_en = 1'b1;

        // random mix
        for (int n = 0; n < 40; n++) begin
            int op;
            op = int'($urandom_range(3, 0));
            case (op)
                0: repeat (int'($urandom_range(6, 1))) step_addr();
                1: begin
                    hv_en = ($urandom_range(4, 0) != 0);
                    prog_op(M_WR, 8'($urandom), 1'($urandom), "R3 random write");
                    hv_en = 1'b1;
                end
                2: read_chk("R2 random read");
                default: restart_en();
            endcase
        end

        // R8 lock bit 1 blocks code writes but not verify
        prog_op(M_LB1, 8'h00, 1'b0, "R8 set lb1");
        prog_op(M_WR, 8'h00, 1'b0, "R8 write under lb1");
        read_chk("R8 verify under lb1");

        // R8 both locks block verify; R9 signature still readable
        prog_op(M_LB2, 8'h00, 1'b0, "R8 set lb2");
        read_chk("R8 verify blocked");
        mode_sel = M_SIG;
        restart_en();
        chk("R9 sig under locks", 32'(data_out), 32'h1E);

        // R7 short hold does nothing, full hold erases
        erase_op(ECYC - 3);
        read_chk("R7 short hold keeps locks");
        erase_op(ECYC + 2);
        read_chk("R7 erased byte");
        repeat (3) step_addr();
        read_chk("R7 erased byte later");
        prog_op(M_WR, 8'h77, 1'b0, "R8 locks cleared by erase");

        mode_sel = M_IDLE;
        tick();
        chk("R10 oe in idle mode", 32'(data_oe), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule